// File: doc/BRIEF.md
# Quadratic Delay and Phase Model Evaluator

This block produces the time-varying geometric model for one station over one integration of a correlator front end. The control side writes three coefficients of a quadratic delay model and three of a quadratic phase model into a staging register at any time. When the integration start strobe arrives, the staged sets are committed and both polynomials restart from their constant terms. After that, the delay model advances once per FFT tick and the phase model advances once per sample tick. Neither evaluator uses a multiplier: each one is a forward-difference accumulator.

The delay value is a fixed-point number in units of 1/256 sample. Its upper bits form an integer sample offset, which picks the first sample of the integration. Its low eight bits form a fraction, which is converted into a phase step at the band centre for use after the FFT. The phase value is a 64-bit turn count that feeds a quadrature mixer once per sample.

Top module: `qme_model_eval`

## Requirements
- R1: After synchronous reset, `dly_int`, `dly_frac`, `frac_phase` and `mix_phase` are all zero.
- R2: One cycle after `integ_start` is high at a clock edge, the 48-bit delay equals the staged delay constant term and `mix_phase` equals the staged phase constant term.
- R3: Each `fft_tick` after a start advances the delay. After n ticks it equals d0 + d1·n + d2·n² modulo 2^48, with coefficients in 1/256-sample units.
- R4: Each `samp_tick` after a start advances the phase. After m ticks it equals p0 + p1·m + p2·m² modulo 2^64.
- R5: A cycle with no tick and no start leaves all outputs unchanged.
- R6: `dly_int` is bits 47:8 of the delay (two's complement, whole samples) and `dly_frac` is bits 7:0 (1/256 sample).
- R7: `frac_phase` equals `dly_frac`·CTR_STEP modulo 2^16, in units of 1/65536 turn. The default CTR_STEP of 64 places the band centre at a quarter of the sample rate.
- R8: A coefficient write during an integration does not change the running outputs. The written values take effect only at the next `integ_start`.
- R9: When `integ_start` coincides with a tick, the start wins and the tick is dropped. When it coincides with `coef_we`, the start uses the previously staged set and the new values wait for the following start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Write all six coefficients into the staging register |
| dly_c0 | input | 48 | Delay constant term |
| dly_c1 | input | 48 | Delay linear term (per FFT) |
| dly_c2 | input | 48 | Delay quadratic term (per FFT squared) |
| ph_c0 | input | 64 | Phase constant term |
| ph_c1 | input | 64 | Phase linear term (per sample) |
| ph_c2 | input | 64 | Phase quadratic term (per sample squared) |
| integ_start | input | 1 | Integration boundary: commit staged set and restart |
| fft_tick | input | 1 | Advance delay model by one FFT |
| samp_tick | input | 1 | Advance phase model by one sample |
| dly_int | output | 40 | Integer sample offset |
| dly_frac | output | 8 | Fractional delay, 1/256 sample |
| frac_phase | output | 16 | Band-centre phase of the fractional delay |
| mix_phase | output | 64 | Mixer phase, turns scaled by 2^64 |

## Verification
The assertions check on every cycle three properties: a restart loads the constant term, an idle cycle holds every accumulator, and a write during an integration leaves the delay untouched. They also check that a zero fraction gives a zero band-centre phase. They cannot confirm that a long run of ticks traces the exact quadratic. The bench does that by evaluating the closed-form polynomial directly against tick counts, including negative coefficients, modular wrap, and starts that collide with ticks and writes.

// File: rtl/qme_pkg.sv
package qme_pkg;
    localparam int DLY_W  = 48;
    localparam int PH_W   = 64;
    localparam int FRAC_W = 8;
    localparam int INT_W  = DLY_W - FRAC_W;
    localparam int FPH_W  = 16;

    typedef struct packed {
        logic [DLY_W-1:0] c0;
        logic [DLY_W-1:0] c1;
        logic [DLY_W-1:0] c2;
    } dly_coef_t;

    typedef struct packed {
        logic [PH_W-1:0] c0;
        logic [PH_W-1:0] c1;
        logic [PH_W-1:0] c2;
    } ph_coef_t;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } dly_split_t;

    function automatic logic [FPH_W-1:0] frac_to_phase(
        input logic [FRAC_W-1:0] f, input logic [FPH_W-1:0] step);
        return FPH_W'(f) * step;
    endfunction
endpackage

// File: rtl/qme_fdiff.sv
module qme_fdiff #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         step,
    input  logic [W-1:0] c0,
    input  logic [W-1:0] c1,
    input  logic [W-1:0] c2,
    output logic [W-1:0] value
);
    logic [W-1:0] acc, d1, d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            d1  <= '0;
            d2  <= '0;
        end else if (init) begin
            acc <= c0;
            d1  <= c1 + c2;
            d2  <= c2 << 1;
        end else if (step) begin
            acc <= acc + d1;
            d1  <= d1 + d2;
        end
    end

    assign value = acc;

    // R2: a restart lands on the constant term
    a_r2_init_loads_c0: assert property (@(posedge clk) disable iff (rst)
        init |=> value == $past(c0));

    // R5: no step and no restart means no motion
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!init && !step) |=> $stable(value));
endmodule

// File: rtl/qme_coef_store.sv
module qme_coef_store
    import qme_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  dly_coef_t dly_in,
    input  ph_coef_t  ph_in,
    output dly_coef_t dly_staged,
    output ph_coef_t  ph_staged
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_staged <= '0;
            ph_staged  <= '0;
        end else if (we) begin
            dly_staged <= dly_in;
            ph_staged  <= ph_in;
        end
    end
endmodule

// File: rtl/qme_model_eval.sv
module qme_model_eval
    import qme_pkg::*;
#(
    parameter logic [FPH_W-1:0] CTR_STEP = 16'd64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               coef_we,
    input  logic [DLY_W-1:0]   dly_c0,
    input  logic [DLY_W-1:0]   dly_c1,
    input  logic [DLY_W-1:0]   dly_c2,
    input  logic [PH_W-1:0]    ph_c0,
    input  logic [PH_W-1:0]    ph_c1,
    input  logic [PH_W-1:0]    ph_c2,
    input  logic               integ_start,
    input  logic               fft_tick,
    input  logic               samp_tick,
    output logic [INT_W-1:0]   dly_int,
    output logic [FRAC_W-1:0]  dly_frac,
    output logic [FPH_W-1:0]   frac_phase,
    output logic [PH_W-1:0]    mix_phase
);
    dly_coef_t  dly_wr, dly_stg;
    ph_coef_t   ph_wr, ph_stg;
    logic [DLY_W-1:0] dly_val;
    dly_split_t split;

    assign dly_wr = '{c0: dly_c0, c1: dly_c1, c2: dly_c2};
    assign ph_wr  = '{c0: ph_c0,  c1: ph_c1,  c2: ph_c2};

    qme_coef_store u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (coef_we),
        .dly_in     (dly_wr),
        .ph_in      (ph_wr),
        .dly_staged (dly_stg),
        .ph_staged  (ph_stg)
    );

    // start has priority over a coincident tick inside each evaluator
    qme_fdiff #(.W(DLY_W)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .init  (integ_start),
        .step  (fft_tick),
        .c0    (dly_stg.c0),
        .c1    (dly_stg.c1),
        .c2    (dly_stg.c2),
        .value (dly_val)
    );

    qme_fdiff #(.W(PH_W)) u_ph (
        .clk   (clk),
        .rst   (rst),
        .init  (integ_start),
        .step  (samp_tick),
        .c0    (ph_stg.c0),
        .c1    (ph_stg.c1),
        .c2    (ph_stg.c2),
        .value (mix_phase)
    );

    assign split      = dly_split_t'(dly_val);
    assign dly_int    = split.whole;
    assign dly_frac   = split.frac;
    assign frac_phase = frac_to_phase(split.frac, CTR_STEP);

    // R8: a write alone never disturbs the running delay
    a_r8_write_no_disturb: assert property (@(posedge clk) disable iff (rst)
        (coef_we && !integ_start && !fft_tick) |=> $stable(dly_val));

    // R7: zero fraction gives zero band-centre phase
    always_comb begin
        if (!rst) begin
            a_r7_zero_frac: assert (dly_frac != '0 || frac_phase == '0);
        end
    end
endmodule

// File: tb/tb_qme_model_eval.sv
module tb_qme_model_eval;
    logic clk = 1'b0;
    logic rst;
    logic coef_we, integ_start, fft_tick, samp_tick;
    logic [47:0] dly_c0, dly_c1, dly_c2;
    logic [63:0] ph_c0, ph_c1, ph_c2;
    logic [39:0] dly_int;
    logic [7:0]  dly_frac;
    logic [15:0] frac_phase;
    logic [63:0] mix_phase;

    always #10 clk = ~clk;

    qme_model_eval dut (
        .clk(clk), .rst(rst), .coef_we(coef_we),
        .dly_c0(dly_c0), .dly_c1(dly_c1), .dly_c2(dly_c2),
        .ph_c0(ph_c0), .ph_c1(ph_c1), .ph_c2(ph_c2),
        .integ_start(integ_start), .fft_tick(fft_tick), .samp_tick(samp_tick),
        .dly_int(dly_int), .dly_frac(dly_frac),
        .frac_phase(frac_phase), .mix_phase(mix_phase)
    );

    // behavioural reference: staged and committed sets, tick counters
    logic [47:0] s_d0, s_d1, s_d2, a_d0, a_d1, a_d2, n_fft;
    logic [63:0] s_p0, s_p1, s_p2, a_p0, a_p1, a_p2, m_smp;
    int vectors = 0;
    int errors  = 0;
    bit finished = 0;
    string tag = "R1";

    task automatic model_edge();
        if (rst) begin
            {s_d0, s_d1, s_d2, a_d0, a_d1, a_d2, n_fft} = '0;
            {s_p0, s_p1, s_p2, a_p0, a_p1, a_p2, m_smp} = '0;
        end else begin
            if (integ_start) begin
                a_d0 = s_d0; a_d1 = s_d1; a_d2 = s_d2;
                a_p0 = s_p0; a_p1 = s_p1; a_p2 = s_p2;
                n_fft = '0; m_smp = '0;
            end else begin
                if (fft_tick)  n_fft = n_fft + 1;
                if (samp_tick) m_smp = m_smp + 1;
            end
            if (coef_we) begin
                s_d0 = dly_c0; s_d1 = dly_c1; s_d2 = dly_c2;
                s_p0 = ph_c0;  s_p1 = ph_c1;  s_p2 = ph_c2;
            end
        end
    endtask

    task automatic compare();
        logic [47:0] ed;
        logic [63:0] ep;
        logic [15:0] ef;
        ed = a_d0 + a_d1 * n_fft + a_d2 * n_fft * n_fft;
        ep = a_p0 + a_p1 * m_smp + a_p2 * m_smp * m_smp;
        ef = 16'(ed[7:0]) * 16'd64;
        vectors++;
        if ({dly_int, dly_frac} !== ed || mix_phase !== ep || frac_phase !== ef) begin
            errors++;
            $display("FAIL %s: dly=%h frac_ph=%h ph=%h expected dly=%h frac_ph=%h ph=%h",
                     tag, {dly_int, dly_frac}, frac_phase, mix_phase, ed, ef, ep);
        end
    endtask

    task automatic cyc(input bit we, input bit st, input bit ft, input bit sp);
        coef_we = we; integ_start = st; fft_tick = ft; samp_tick = sp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic set_coefs(input logic [47:0] d0, d1, d2, input logic [63:0] p0, p1, p2);
        dly_c0 = d0; dly_c1 = d1; dly_c2 = d2;
        ph_c0 = p0;  ph_c1 = p1;  ph_c2 = p2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        coef_we = 0; integ_start = 0; fft_tick = 0; samp_tick = 0;
        set_coefs('0, '0, '0, '0, '0, '0);
        @(negedge clk);
        cyc(0, 0, 0, 0);
        rst = 1'b0;
        tag = "R1";
        cyc(0, 0, 0, 0);

        // R2 / R6 / R7: commit and restart at constant term with a fraction
        tag = "R2";
        set_coefs(48'h0000_0012_34A7, 48'h0000_0000_0113, 48'h0000_0000_0005,
                  64'h1111_2222_3333_4444, 64'h0000_0100_0000_0000, 64'h0000_0000_0001_0000);
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        tag = "R6";
        cyc(0, 0, 0, 0);

        // R3: FFT-rate stepping; R7 band-centre phase tracks fraction
        tag = "R3";
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0);
        // R4: sample-rate stepping
        tag = "R4";
        for (int i = 0; i < 200; i++) cyc(0, 0, 0, 1);
        // R5: idle
        tag = "R5";
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0);

        // R8: writes mid-integration do not disturb
        tag = "R8";
        set_coefs(48'hFFFF_FFFF_0000, 48'hFFFF_FFFF_FF80, 48'hFFFF_FFFF_FFFF,
                  64'hFFFF_0000_0000_0000, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE);
        for (int i = 0; i < 20; i++) cyc(1, 0, i[0], i[1]);
        tag = "R2";
        cyc(0, 1, 0, 0);
        // R3 / R4: negative slopes and modular wrap
        tag = "R3";
        for (int i = 0; i < 300; i++) cyc(0, 0, 1, 1);

        // R9: start coincides with ticks and with a write
        tag = "R9";
        set_coefs(48'h0000_0000_0A55, 48'h0000_0000_0040, 48'h0000_0000_0003,
                  64'h0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0007);
        cyc(1, 1, 1, 1);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1);
        cyc(0, 1, 1, 1);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1);

        // mixed random traffic with random coefficients
        tag = "R3";
        for (int k = 0; k < 8; k++) begin
            set_coefs({$urandom, $urandom} , 48'($urandom), 48'($urandom % 64),
                      {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
            cyc(1, 0, 0, 0);
            cyc(0, 1, 0, 0);
            for (int i = 0; i < 150; i++) begin
                automatic int r = $urandom;
                cyc(r[5:0] == 0, 0, r[8:7] == 0, r[9]);
            end
        end
        finish_run();
    end
endmodule